// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block gathers up to eight interrupt request lines and forwards the most urgent unmasked one to a processor as a single request signal. The processor answers with a one-cycle acknowledge. In that same cycle the block drives an 8-bit vector, formed from a programmable base and the index of the winning line. Line 0 has the highest priority. A line that is in service blocks every line of equal or lower priority until software retires it with a specific end-of-interrupt command, unless the block has been set up for automatic retirement at acknowledge.

Software talks to the block through a byte-wide port with one address bit. Writing a command byte with bit 4 set starts an initialization sequence of data-port words. The sequence sets the vector base, optionally consumes a cascade word, and optionally selects the end-of-interrupt mode. After initialization the data port holds the line mask. The command port selects which status register (pending requests or in-service) is read back, and accepts specific end-of-interrupt commands. Each line can be set to edge or level sensing by an input, except lines 0 to 2, which always stay edge-sensed.

Top module: `pic_core`

## Requirements
- R1: After reset the block is uninitialized, the mask reads 0x00, and `int_req` stays low whatever the request lines do until an initialization sequence completes.
- R2: A command-port write (`bus_a0`=0) with bit 4 set starts initialization. With 0x11 it takes three further data-port words: the base (bits 7:3 used), a cascade word, and a mode word. The vector is always {base[7:3], line index}.
- R3: In the first init word, bit 1 = 1 skips the cascade word and bit 0 = 0 skips the mode word and selects normal end-of-interrupt. With 0x12 the block is ready after the base word alone.
- R4: Outside initialization, a data-port write loads the mask and a data-port read returns it. A mask bit of 1 keeps its line from raising `int_req`, but the line's request is still recorded.
- R5: Command byte 0x0A selects the request register for command-port reads and 0x0B selects the in-service register. The selection persists across other writes until it is changed.
- R6: Line 0 has the highest priority. `int_req` is high only when the lowest-numbered unmasked pending line is numbered below every set in-service bit.
- R7: When `int_ack` is high while `int_req` is high, `vec_out` carries the winner's vector in that same cycle. At the next edge the winner's pending bit clears and, in normal mode, its in-service bit sets.
- R8: Command byte 0x60+n (n = 0..7) clears in-service bit n only.
- R9: A mode word with bit 1 set (0x03) selects auto end-of-interrupt: an acknowledge leaves the in-service register unchanged.
- R10: An acknowledge while `int_req` is low is spurious. It yields vector base+7 and changes no in-service bit, even when line 7 is masked.
- R11: A line with `trig_level` set (lines 3..7 only) requests while its input is high, and it requests again after retirement if the input is still high. An edge-sensed line needs a fresh low-to-high transition, and its pending bit drops if the input falls before acknowledge.
- R12: Starting initialization clears the mask, the pending and in-service registers, and the auto end-of-interrupt mode, and selects the request register for readback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per byte |
| bus_a0 | input | 1 | Register address: 0 = command port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data: mask at data port, selected status register at command port |
| irq_in | input | 8 | Interrupt request lines |
| trig_level | input | 8 | Per-line level-sense select (ignored for lines 0..2) |
| int_req | output | 1 | Interrupt request toward the processor |
| int_ack | input | 1 | Single-cycle interrupt acknowledge |
| vec_out | output | 8 | Interrupt vector, valid while `int_ack` is high |

## Verification
On every cycle the assertions check these points: no request is raised before initialization, a raised request always has an unmasked pending line that outranks the in-service set, and the vector always carries the programmed base. At each acknowledge they also check the in-service effects: a real acknowledge in normal mode sets the winner's bit, while a spurious or auto-EOI acknowledge changes nothing. A specific end-of-interrupt must clear its bit, and starting initialization must clear the state. The bench scenarios cover the rest: the ordering of the init word sequence and its shortened variants, the persistence of the readback select, level lines that re-request after retirement, and the reserved lines that ignore a level setting. Its behavioural model also compares request, readback and vector on every cycle.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PIC_LINES  = 8;
  localparam int PIC_IDX_W  = $clog2(PIC_LINES);
  localparam int PIC_DATA_W = 8;
  localparam int PIC_BASE_W = PIC_DATA_W - PIC_IDX_W;

  // command byte fields
  localparam int CMD_INIT_BIT = 4;
  localparam int CMD_SEL_BIT  = 3;
  localparam logic [2:0] CMD_SPEC_EOI = 3'b011;

  typedef enum logic [1:0] {
    SEQ_RUN  = 2'd0,
    SEQ_BASE = 2'd1,
    SEQ_CASC = 2'd2,
    SEQ_MODE = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic                 hit;
    logic [PIC_IDX_W-1:0] idx;
  } pick_t;

  // lowest-numbered set bit wins
  function automatic pick_t pick_first(input logic [PIC_LINES-1:0] v);
    pick_t r;
    r.hit = 1'b0;
    r.idx = '0;
    for (int i = PIC_LINES - 1; i >= 0; i--) begin
      if (v[i]) begin
        r.hit = 1'b1;
        r.idx = PIC_IDX_W'(i);
      end
    end
    return r;
  endfunction

  function automatic logic outranks(input pick_t req, input pick_t svc);
    return req.hit && (!svc.hit || (req.idx < svc.idx));
  endfunction

  function automatic logic [PIC_DATA_W-1:0] make_vector(
      input logic [PIC_BASE_W-1:0] base, input logic [PIC_IDX_W-1:0] idx);
    return {base, idx};
  endfunction

  function automatic logic [PIC_LINES-1:0] line_bit(input logic [PIC_IDX_W-1:0] idx);
    return PIC_LINES'(1) << idx;
  endfunction
endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
  import pic_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  a0,
  input  logic [PIC_DATA_W-1:0] wdata,
  output logic                  init_start,
  output logic                  eoi_hit,
  output logic [PIC_IDX_W-1:0]  eoi_line,
  output logic                  ready,
  output logic [PIC_BASE_W-1:0] base,
  output logic                  aeoi,
  output logic [PIC_LINES-1:0]  mask,
  output logic                  sel_isr
);
  seq_state_e state_q;
  logic       need_mode_q;
  logic       single_q;
  logic       cmd_wr, data_wr, sel_wr;

  assign cmd_wr     = wr_en && !a0;
  assign data_wr    = wr_en && a0;
  assign init_start = cmd_wr && wdata[CMD_INIT_BIT];
  assign sel_wr     = cmd_wr && !wdata[CMD_INIT_BIT] && wdata[CMD_SEL_BIT];
  assign eoi_hit    = cmd_wr && !wdata[CMD_INIT_BIT] && !wdata[CMD_SEL_BIT]
                      && (wdata[7:5] == CMD_SPEC_EOI);
  assign eoi_line   = wdata[PIC_IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SEQ_RUN;
      ready       <= 1'b0;
      base        <= '0;
      aeoi        <= 1'b0;
      mask        <= '0;
      sel_isr     <= 1'b0;
      need_mode_q <= 1'b0;
      single_q    <= 1'b0;
    end else if (init_start) begin
      state_q     <= SEQ_BASE;
      ready       <= 1'b0;
      aeoi        <= 1'b0;
      mask        <= '0;
      sel_isr     <= 1'b0;
      need_mode_q <= wdata[0];
      single_q    <= wdata[1];
    end else begin
      if (sel_wr && wdata[1]) sel_isr <= wdata[0];
      if (data_wr) begin
        unique case (state_q)
          SEQ_RUN: mask <= wdata;
          SEQ_BASE: begin
            base <= wdata[PIC_DATA_W-1:PIC_IDX_W];
            if (!single_q) begin
              state_q <= SEQ_CASC;
            end else if (need_mode_q) begin
              state_q <= SEQ_MODE;
            end else begin
              state_q <= SEQ_RUN;
              ready   <= 1'b1;
            end
          end
          SEQ_CASC: begin
            if (need_mode_q) begin
              state_q <= SEQ_MODE;
            end else begin
              state_q <= SEQ_RUN;
              ready   <= 1'b1;
            end
          end
          SEQ_MODE: begin
            aeoi    <= wdata[1];
            state_q <= SEQ_RUN;
            ready   <= 1'b1;
          end
          default: state_q <= SEQ_RUN;
        endcase
      end
    end
  end
endmodule

// File: rtl/pic_request_reg.sv
module pic_request_reg
  import pic_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear_all,
  input  logic [PIC_LINES-1:0] irq_in,
  input  logic [PIC_LINES-1:0] level_sel,
  input  logic [PIC_LINES-1:0] ack_clr,
  output logic [PIC_LINES-1:0] irr
);
  logic [PIC_LINES-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= irq_in;
  end

  for (genvar g = 0; g < PIC_LINES; g++) begin : g_line
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           bit_q <= 1'b0;
      else if (clear_all)                   bit_q <= 1'b0;
      else if (ack_clr[g])                  bit_q <= 1'b0;
      else if (level_sel[g])                bit_q <= irq_in[g];
      else if (irq_in[g] && !prev_q[g])     bit_q <= 1'b1;
      else if (!irq_in[g])                  bit_q <= 1'b0;
    end
    assign irr[g] = bit_q;
  end
endmodule

// File: rtl/pic_priority.sv
module pic_priority
  import pic_pkg::*;
(
  input  logic                 ready,
  input  logic [PIC_LINES-1:0] irr,
  input  logic [PIC_LINES-1:0] mask,
  input  logic [PIC_LINES-1:0] isr,
  output logic                 req_win,
  output logic [PIC_IDX_W-1:0] win_idx
);
  pick_t pend_pick, svc_pick;

  assign pend_pick = pick_first(irr & ~mask);
  assign svc_pick  = pick_first(isr);
  assign req_win   = ready && outranks(pend_pick, svc_pick);
  assign win_idx   = pend_pick.idx;
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_pkg::*;
#(
  parameter logic [PIC_LINES-1:0] EDGE_ONLY = 8'h07
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_a0,
  input  logic [PIC_DATA_W-1:0] bus_wdata,
  output logic [PIC_DATA_W-1:0] bus_rdata,
  input  logic [PIC_LINES-1:0]  irq_in,
  input  logic [PIC_LINES-1:0]  trig_level,
  output logic                  int_req,
  input  logic                  int_ack,
  output logic [PIC_DATA_W-1:0] vec_out
);
  localparam logic [PIC_IDX_W-1:0] SPUR_LINE = PIC_IDX_W'(PIC_LINES - 1);

  logic                  init_start, eoi_hit, ready_q, aeoi_q, sel_isr_q;
  logic [PIC_IDX_W-1:0]  eoi_line, win_idx;
  logic [PIC_BASE_W-1:0] base_q;
  logic [PIC_LINES-1:0]  mask_q, irr_q, isr_q, ack_clr, isr_set, isr_clr;
  logic                  req_win, ack_take;

  pic_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .a0(bus_a0), .wdata(bus_wdata),
    .init_start(init_start), .eoi_hit(eoi_hit), .eoi_line(eoi_line),
    .ready(ready_q), .base(base_q), .aeoi(aeoi_q), .mask(mask_q), .sel_isr(sel_isr_q)
  );

  pic_request_reg u_irr (
    .clk(clk), .rst_n(rst_n), .clear_all(init_start), .irq_in(irq_in),
    .level_sel(trig_level & ~EDGE_ONLY), .ack_clr(ack_clr), .irr(irr_q)
  );

  pic_priority u_prio (
    .ready(ready_q), .irr(irr_q), .mask(mask_q), .isr(isr_q),
    .req_win(req_win), .win_idx(win_idx)
  );

  assign int_req  = req_win;
  assign ack_take = int_ack && req_win;
  assign ack_clr  = ack_take ? line_bit(win_idx) : '0;
  assign isr_set  = (ack_take && !aeoi_q) ? line_bit(win_idx) : '0;
  assign isr_clr  = eoi_hit ? line_bit(eoi_line) : '0;
  assign vec_out  = make_vector(base_q, req_win ? win_idx : SPUR_LINE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          isr_q <= '0;
    else if (init_start) isr_q <= '0;
    else                 isr_q <= (isr_q & ~isr_clr) | isr_set;
  end

  assign bus_rdata = bus_a0 ? mask_q : (sel_isr_q ? isr_q : irr_q);
endmodule

// File: rtl/pic_core_chk.sv
module pic_core_chk
  import pic_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_wr,
  input logic                  bus_a0,
  input logic [PIC_DATA_W-1:0] bus_wdata,
  input logic                  int_req,
  input logic                  int_ack,
  input logic [PIC_DATA_W-1:0] vec_out,
  input logic                  ready,
  input logic                  aeoi,
  input logic [PIC_BASE_W-1:0] base,
  input logic [PIC_LINES-1:0]  mask,
  input logic [PIC_LINES-1:0]  irr,
  input logic [PIC_LINES-1:0]  isr
);
  logic init_wr, eoi_wr;
  assign init_wr = bus_wr && !bus_a0 && bus_wdata[CMD_INIT_BIT];
  assign eoi_wr  = bus_wr && !bus_a0 && !bus_wdata[CMD_INIT_BIT] && !bus_wdata[CMD_SEL_BIT]
                   && (bus_wdata[7:5] == CMD_SPEC_EOI);

  assert_quiet_until_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !int_req);

  assert_vector_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vec_out[PIC_DATA_W-1:PIC_IDX_W] == base);

  assert_req_unmasked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> ((irr & ~mask) != '0));

  assert_req_outranks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (PIC_LINES'(isr << (PIC_IDX_W'(PIC_LINES - 1) - vec_out[PIC_IDX_W-1:0])) == '0));

  assert_ack_sets_service_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && int_req && !aeoi && !init_wr) |=> isr[$past(vec_out[PIC_IDX_W-1:0])]);

  assert_eoi_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && !int_ack) |=> !isr[$past(bus_wdata[PIC_IDX_W-1:0])]);

  assert_auto_eoi_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && aeoi && !bus_wr) |=> (isr == $past(isr)));

  assert_spurious_vector_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !int_req) |-> (vec_out[PIC_IDX_W-1:0] == PIC_IDX_W'(PIC_LINES - 1)));

  assert_spurious_no_service_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !int_req && !bus_wr) |=> (isr == $past(isr)));

  assert_init_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    init_wr |=> (mask == '0 && isr == '0 && irr == '0 && !ready));
endmodule

bind pic_core pic_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_a0(bus_a0), .bus_wdata(bus_wdata),
  .int_req(int_req), .int_ack(int_ack), .vec_out(vec_out),
  .ready(ready_q), .aeoi(aeoi_q), .base(base_q), .mask(mask_q), .irr(irr_q), .isr(isr_q)
);

// File: tb/pic_core_tb_top.sv
module pic_core_tb_top;
  localparam int CLK_PERIOD = 10;

  bit         clk;
  logic       rst_n;
  logic       bus_wr, bus_a0, int_ack;
  logic [7:0] bus_wdata, irq, lvl;
  logic [7:0] bus_rdata, vec_out;
  logic       int_req;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_core dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_a0(bus_a0), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_in(irq), .trig_level(lvl), .int_req(int_req),
    .int_ack(int_ack), .vec_out(vec_out)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0] m_irr, m_isr, m_mask, m_prev, n_irr, n_isr;
  logic [4:0] m_base;
  bit         m_sel, m_ready, m_aeoi, m_need4, m_single, m_take;
  int         m_phase, m_p;

  function automatic int first_set(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic bit m_req();
    int p = first_set(m_irr & ~m_mask);
    int s = first_set(m_isr);
    return m_ready && (p < 8) && (p < s);
  endfunction

  function automatic logic [7:0] m_vec();
    int p = first_set(m_irr & ~m_mask);
    return m_base * 8 + (m_req() ? p : 7);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_irr = 0; m_isr = 0; m_mask = 0; m_prev = 0; m_base = 0;
      m_sel = 0; m_ready = 0; m_aeoi = 0; m_need4 = 0; m_single = 0; m_phase = 0;
    end else begin
      m_p    = first_set(m_irr & ~m_mask);
      m_take = int_ack && m_req();
      for (int i = 0; i < 8; i++) begin
        if (m_take && i == m_p)              n_irr[i] = 1'b0;
        else if (lvl[i] && i >= 3)           n_irr[i] = irq[i];
        else if (irq[i] && !m_prev[i])       n_irr[i] = 1'b1;
        else if (!irq[i])                    n_irr[i] = 1'b0;
        else                                 n_irr[i] = m_irr[i];
      end
      n_isr = m_isr;
      if (bus_wr && !bus_a0 && bus_wdata[7:3] == 5'b01100) n_isr[bus_wdata[2:0]] = 1'b0;
      if (m_take && !m_aeoi) n_isr[m_p] = 1'b1;
      if (bus_wr && !bus_a0 && bus_wdata[4]) begin
        n_irr = 0; n_isr = 0; m_mask = 0; m_sel = 0; m_aeoi = 0; m_ready = 0;
        m_need4 = bus_wdata[0]; m_single = bus_wdata[1]; m_phase = 1;
      end else if (bus_wr && !bus_a0 && bus_wdata[3]) begin
        if (bus_wdata[1:0] == 2'b10) m_sel = 0;
        if (bus_wdata[1:0] == 2'b11) m_sel = 1;
      end else if (bus_wr && bus_a0) begin
        if (m_phase == 0) m_mask = bus_wdata;
        else if (m_phase == 1) begin
          m_base = bus_wdata[7:3];
          m_phase = !m_single ? 2 : (m_need4 ? 3 : 0);
        end else if (m_phase == 2) m_phase = m_need4 ? 3 : 0;
        else begin
          m_aeoi = bus_wdata[1];
          m_phase = 0;
        end
        if (m_phase == 0) m_ready = 1;
      end
      m_irr = n_irr; m_isr = n_isr; m_prev = irq;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R6 int_req", {7'd0, int_req}, {7'd0, m_req()});
      chk("R5 readback", bus_rdata, bus_a0 ? m_mask : (m_sel ? m_isr : m_irr));
      chk("R2 vector", vec_out, m_vec());
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr_reg(input logic a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_a0 = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk); irq = v;
    @(negedge clk);
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    bus_a0 = a; #1; d = bus_rdata;
  endtask

  task automatic do_ack(output logic [7:0] v);
    @(negedge clk); int_ack = 1; #1; v = vec_out;
    @(negedge clk); int_ack = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog expired actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 0; bus_wr = 0; bus_a0 = 0; bus_wdata = 0; irq = 0; lvl = 0; int_ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state and uninitialized silence
    chk("R1 int_req after reset", {7'd0, int_req}, 8'h00);
    rd(1, d); chk("R1 mask after reset", d, 8'h00);
    set_irq(8'h08);
    chk("R1 no request before init", {7'd0, int_req}, 8'h00);

    // R2 full init sequence, normal EOI
    wr_reg(0, 8'h11); wr_reg(1, 8'h20); wr_reg(1, 8'h04); wr_reg(1, 8'h01);
    chk("R12 init cleared pending", {7'd0, int_req}, 8'h00);
    rd(0, d); chk("R12 request register empty", d, 8'h00);
    set_irq(8'h00); set_irq(8'h08);
    chk("R7 request raised", {7'd0, int_req}, 8'h01);
    do_ack(d); chk("R2 vector line 3", d, 8'h23);
    wr_reg(0, 8'h0B);
    rd(0, d); chk("R7 in-service set", d, 8'h08);

    // R6 priority against in-service
    set_irq(8'h28);
    chk("R6 lower line blocked", {7'd0, int_req}, 8'h00);
    set_irq(8'h2A);
    chk("R6 higher line passes", {7'd0, int_req}, 8'h01);
    do_ack(d); chk("R6 vector line 1", d, 8'h21);
    rd(0, d); chk("R5 select persists", d, 8'h0A);

    // R8 specific EOI
    wr_reg(0, 8'h61);
    rd(0, d); chk("R8 only bit 1 cleared", d, 8'h08);
    chk("R6 line 5 still blocked", {7'd0, int_req}, 8'h00);
    wr_reg(0, 8'h63);
    chk("R8 line 5 released", {7'd0, int_req}, 8'h01);
    do_ack(d); chk("R6 vector line 5", d, 8'h25);
    wr_reg(0, 8'h65);
    rd(0, d); chk("R8 all retired", d, 8'h00);

    // R4 mask
    wr_reg(1, 8'hFF);
    rd(1, d); chk("R4 mask readback", d, 8'hFF);
    set_irq(8'h3A);
    chk("R4 masked no request", {7'd0, int_req}, 8'h00);
    wr_reg(0, 8'h0A);
    rd(0, d); chk("R5 request register shows line 4", d, 8'h10);
    wr_reg(1, 8'h00);
    chk("R4 unmask raises", {7'd0, int_req}, 8'h01);
    do_ack(d); chk("R4 vector line 4", d, 8'h24);
    wr_reg(0, 8'h64);

    // R10 spurious acknowledge
    chk("R10 idle", {7'd0, int_req}, 8'h00);
    wr_reg(0, 8'h0B);
    do_ack(d); chk("R10 spurious vector", d, 8'h27);
    rd(0, d); chk("R10 no in-service", d, 8'h00);
    wr_reg(1, 8'h80);
    set_irq(8'hBA);
    do_ack(d); chk("R10 spurious with line 7 masked", d, 8'h27);
    rd(0, d); chk("R10 still no in-service", d, 8'h00);
    set_irq(8'h3A);
    wr_reg(1, 8'h00);

    // R11 level-sensed line 6
    @(negedge clk); lvl = 8'h40; irq = 8'h7A;
    @(negedge clk);
    chk("R11 level request", {7'd0, int_req}, 8'h01);
    do_ack(d); chk("R11 vector line 6", d, 8'h26);
    wr_reg(0, 8'h66);
    chk("R11 level re-request", {7'd0, int_req}, 8'h01);
    do_ack(d); wr_reg(0, 8'h66);
    @(negedge clk); lvl = 8'h00; irq = 8'h3A;
    @(negedge clk);
    // R11 reserved line 1 stays edge
    @(negedge clk); lvl = 8'h02;
    repeat (3) @(negedge clk);
    chk("R11 line 1 ignores level select", {7'd0, int_req}, 8'h00);
    @(negedge clk); lvl = 8'h00;

    // R9 auto-EOI, R12 select reset
    set_irq(8'h00);
    wr_reg(0, 8'h11); wr_reg(1, 8'h28); wr_reg(1, 8'h02); wr_reg(1, 8'h03);
    set_irq(8'h04);
    rd(0, d); chk("R12 select back to request register", d, 8'h04);
    do_ack(d); chk("R2 vector base 0x28 line 2", d, 8'h2A);
    wr_reg(0, 8'h0B);
    rd(0, d); chk("R9 auto EOI leaves in-service empty", d, 8'h00);

    // R3 shortened sequence
    set_irq(8'h00);
    wr_reg(0, 8'h12); wr_reg(1, 8'h40);
    set_irq(8'h01);
    chk("R3 ready after base only", {7'd0, int_req}, 8'h01);
    do_ack(d); chk("R3 vector base 0x40", d, 8'h40);
    wr_reg(0, 8'h0B);
    rd(0, d); chk("R3 normal EOI mode", d, 8'h01);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule